// File: doc/BRIEF.md
# Video Payload Length Enforcer

This block turns 24-bit pixels from a parallel video port into a byte stream that carries the payload of one long packet. The length of the payload is the word count that the packet header will carry. The block emits exactly that many bytes, no matter how long the source keeps its data-enable high. A packet starts with a one-cycle start pulse that carries the word count and a mode select. The block then consumes pixels, splits each one into bytes and queues them in a small byte buffer. A valid/ready handshake drains the buffer, and a last flag marks the final byte.

The block runs on the system clock. A one-cycle pixel strobe marks each pixel-clock pulse of the port. There are two modes:

- **Video mode:** pixels are taken on strobes with data-enable high. If data-enable falls early, the remaining payload is filled with zero bytes, one zero pixel per strobe. Pixels that arrive after the count is reached are dropped.
- **Command mode:** data-enable is ignored. The source is paced by a stall output instead. A pixel is taken on every strobe during which stall is low.

Top module: `vid_payload_enforcer`

## Requirements
- R1: For a packet with word count WC, exactly WC bytes leave on the byte port. Byte i is bits [8*(i%3)+7 : 8*(i%3)] of the i/3-th pixel taken (least significant byte first). No byte is valid while the block is idle.
- R2: byte_last is 1 on the final byte of the payload and 0 on every other byte.
- R3: In video mode, suppose data-enable is low on a strobe after at least one pixel was taken. The bytes already taken are sent first. Then each later strobe adds up to three zero bytes until WC bytes exist.
- R4: In video mode, pixels strobed with data-enable high after WC bytes are reached are discarded. A pixel that crosses the WC boundary contributes only its low bytes.
- R5: A start with WC = 0 produces no bytes, and pkt_done is 1 on the following cycle.
- R6: In command mode, pix_de has no effect. A pixel is taken on each strobe during which pix_stall is 0, whatever the level of pix_de.
- R7: pix_stall is 1 whenever the block is idle, the count has been reached, or the byte buffer has fewer than three free places.
- R8: While byte_valid is 1 and byte_ready is 0, byte_valid, byte_data and byte_last hold on the next cycle.
- R9: A start pulse while a packet is in progress is ignored. The running packet keeps its word count.
- R10: pkt_done pulses for one cycle, on the cycle after the handshake of the last byte.
- R11: After reset, byte_valid is 0, pkt_done is 0 and pix_stall is 1.
- R12: In video mode, strobes with data-enable low before the first pixel is taken neither add bytes nor start padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle pulse that begins a packet |
| pkt_wc | input | WC_W | Payload byte count, sampled with pkt_start |
| cmd_mode | input | 1 | 1 selects command mode, sampled with pkt_start |
| pix_pulse | input | 1 | One-cycle strobe per pixel-clock pulse |
| pix_de | input | 1 | Data-enable of the video port |
| pix_data | input | 3*8 | Pixel word |
| pix_stall | output | 1 | 1 tells the command-mode source to hold its pixel |
| byte_valid | output | 1 | Byte available on byte_data |
| byte_ready | input | 1 | Sink accepts the byte |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Marks the final payload byte |
| pkt_done | output | 1 | One-cycle pulse when the packet is complete |

## Verification
The bench drives several data-enable patterns against the word count:
- a burst that exactly fills the count;
- a short burst that needs zero padding, with idle leading strobes;
- long bursts that cross the count both on a pixel boundary and inside a pixel.

Each payload byte is numbered by its own position, so the bytes show where real data ends and padding begins, and where truncation cut a pixel. Command-mode runs hold pix_de low and apply output back-pressure. In those runs, only the stall handshake decides which pixels are taken, so a lost or repeated pixel shows up as a shifted byte sequence.

// File: rtl/vpe_pkg.sv
package vpe_pkg;

    localparam int BYTES_PER_PIX = 3;
    localparam int BYTE_W        = 8;
    localparam int PIX_W         = BYTES_PER_PIX * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_PAD   = 2'd2,
        ST_DRAIN = 2'd3
    } state_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } pay_byte_t;

    // Number of bytes a pixel contributes given the remaining count.
    function automatic logic [1:0] take_bytes(input logic at_least_three,
                                              input logic [1:0] low_bits);
        return at_least_three ? 2'd3 : low_bits;
    endfunction

endpackage

// File: rtl/vpe_ctrl.sv
module vpe_ctrl
    import vpe_pkg::*;
#(
    parameter int WC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [WC_W-1:0] wc,
    input  logic            cmd_mode,
    input  logic            pix_pulse,
    input  logic            pix_de,
    input  logic            fifo_room,
    input  logic            last_popped,
    output logic [1:0]      push_n,
    output logic            push_zero,
    output logic            push_last,
    output logic            stall,
    output logic            done,
    output logic            idle
);

    state_e          state;
    logic [WC_W-1:0] rem;
    logic            mode_cmd;
    logic            de_seen;
    logic [1:0]      n_take;
    logic            in_fill;
    logic            accept_cmd;
    logic            take_vid;
    logic            take_pad;
    logic            push;
    logic            reaches_end;

    always_comb begin
        n_take      = take_bytes(rem >= WC_W'(3), rem[1:0]);
        in_fill     = (state == ST_FILL);
        accept_cmd  = in_fill && mode_cmd && fifo_room;
        take_vid    = in_fill && !mode_cmd && pix_pulse && pix_de && fifo_room;
        take_pad    = (state == ST_PAD) && pix_pulse && fifo_room;
        push        = (accept_cmd && pix_pulse) || take_vid || take_pad;
        push_n      = push ? n_take : 2'd0;
        push_zero   = (state == ST_PAD);
        push_last   = (rem <= WC_W'(3));
        reaches_end = (rem == WC_W'(n_take));
        stall       = !accept_cmd;
        idle        = (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rem      <= '0;
            mode_cmd <= 1'b0;
            de_seen  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (wc == '0) begin
                            done <= 1'b1;
                        end else begin
                            rem      <= wc;
                            mode_cmd <= cmd_mode;
                            de_seen  <= 1'b0;
                            state    <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (push) begin
                        rem     <= rem - WC_W'(n_take);
                        de_seen <= 1'b1;
                        if (reaches_end) state <= ST_DRAIN;
                    end else if (!mode_cmd && pix_pulse && !pix_de && de_seen) begin
                        state <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    if (push) begin
                        rem <= rem - WC_W'(n_take);
                        if (reaches_end) state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (last_popped) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vpe_byte_fifo.sv
module vpe_byte_fifo
    import vpe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_n,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic              wr_zero,
    input  logic              wr_last,
    output logic              room,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_last
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    pay_byte_t       mem [DEPTH];
    pay_byte_t       lane [BYTES_PER_PIX];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [CW-1:0]   count;
    logic            pop;

    for (genvar j = 0; j < BYTES_PER_PIX; j++) begin : g_lane
        assign lane[j].data = wr_zero ? '0 : wr_data[BYTE_W*j +: BYTE_W];
        assign lane[j].last = wr_last && (2'(j) == wr_n - 2'd1);
    end

    assign rd_valid = (count != '0);
    assign pop      = rd_valid && rd_ready;
    assign room     = (count <= CW'(DEPTH - BYTES_PER_PIX));
    assign rd_data  = rd_valid ? mem[rptr].data : '0;
    assign rd_last  = rd_valid && mem[rptr].last;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int j = 0; j < BYTES_PER_PIX; j++) begin
                if (2'(j) < wr_n) mem[wptr + AW'(j)] <= lane[j];
            end
            wptr  <= wptr + AW'(wr_n);
            if (pop) rptr <= rptr + AW'(1);
            count <= count + CW'(wr_n) - CW'(pop);
        end
    end

endmodule

// File: rtl/vid_payload_enforcer.sv
module vid_payload_enforcer
    import vpe_pkg::*;
#(
    parameter int WC_W       = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic [WC_W-1:0]   pkt_wc,
    input  logic              cmd_mode,
    input  logic              pix_pulse,
    input  logic              pix_de,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              pix_stall,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last,
    output logic              pkt_done
);

    logic [1:0] push_n;
    logic       push_zero;
    logic       push_last;
    logic       fifo_room;
    logic       last_popped;
    logic       ctrl_idle;

    assign last_popped = byte_valid && byte_ready && byte_last;

    vpe_ctrl #(.WC_W(WC_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (pkt_start),
        .wc          (pkt_wc),
        .cmd_mode    (cmd_mode),
        .pix_pulse   (pix_pulse),
        .pix_de      (pix_de),
        .fifo_room   (fifo_room),
        .last_popped (last_popped),
        .push_n      (push_n),
        .push_zero   (push_zero),
        .push_last   (push_last),
        .stall       (pix_stall),
        .done        (pkt_done),
        .idle        (ctrl_idle)
    );

    vpe_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (push_n),
        .wr_data  (pix_data),
        .wr_zero  (push_zero),
        .wr_last  (push_last),
        .room     (fifo_room),
        .rd_valid (byte_valid),
        .rd_ready (byte_ready),
        .rd_data  (byte_data),
        .rd_last  (byte_last)
    );

endmodule

// File: rtl/vid_payload_enforcer_chk.sv
module vid_payload_enforcer_chk #(
    parameter int WC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            pkt_start,
    input logic [WC_W-1:0] pkt_wc,
    input logic            pix_stall,
    input logic            byte_valid,
    input logic            byte_ready,
    input logic [7:0]      byte_data,
    input logic            byte_last,
    input logic            pkt_done,
    input logic            ctrl_idle
);

    a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (rst)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) && $stable(byte_last));

    a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready && byte_last |=> pkt_done);

    a_r5_zero_count_done: assert property (@(posedge clk) disable iff (rst)
        ctrl_idle && pkt_start && (pkt_wc == '0) |=> pkt_done && !byte_valid);

    a_r7_stall_when_idle: assert property (@(posedge clk) disable iff (rst)
        ctrl_idle |-> pix_stall);

    a_r1_no_bytes_when_idle: assert property (@(posedge clk) disable iff (rst)
        ctrl_idle |-> !byte_valid);

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);

endmodule

bind vid_payload_enforcer vid_payload_enforcer_chk #(.WC_W(WC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pkt_start  (pkt_start),
    .pkt_wc     (pkt_wc),
    .pix_stall  (pix_stall),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .byte_last  (byte_last),
    .pkt_done   (pkt_done),
    .ctrl_idle  (ctrl_idle)
);

// File: tb/vid_payload_enforcer_tb_top.sv
`timescale 1ns/1ps
module vid_payload_enforcer_tb_top;

    localparam int WC_W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pkt_start = 1'b0;
    logic [WC_W-1:0] pkt_wc = '0;
    logic            cmd_mode = 1'b0;
    logic            pix_pulse = 1'b0;
    logic            pix_de = 1'b0;
    logic [23:0]     pix_data = '0;
    logic            pix_stall;
    logic            byte_valid;
    logic            byte_ready = 1'b1;
    logic [7:0]      byte_data;
    logic            byte_last;
    logic            pkt_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vid_payload_enforcer #(.WC_W(WC_W), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_wc(pkt_wc),
        .cmd_mode(cmd_mode), .pix_pulse(pix_pulse), .pix_de(pix_de),
        .pix_data(pix_data), .pix_stall(pix_stall), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .byte_data(byte_data), .byte_last(byte_last),
        .pkt_done(pkt_done)
    );

    // Collector of handshaken bytes.
    logic [7:0] got_data [64];
    logic       got_last [64];
    int         got_n = 0;
    int         tick = 0;
    int         last_tick = -1;
    int         done_tick = -1;
    bit         done_seen = 0;
    bit         prev_hold = 0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        tick++;
        if (!rst) begin
            if (prev_hold) begin
                check(byte_valid && byte_data == prev_data && byte_last == prev_last,
                      "R8 hold", int'(byte_data), int'(prev_data));
            end
            prev_hold = byte_valid && !byte_ready;
            prev_data = byte_data;
            prev_last = byte_last;
            if (byte_valid && byte_ready) begin
                if (got_n < 64) begin
                    got_data[got_n] = byte_data;
                    got_last[got_n] = byte_last;
                end
                got_n++;
                if (byte_last) last_tick = tick;
            end
            if (pkt_done && !done_seen) begin
                done_seen = 1;
                done_tick = tick;
            end
        end
    end

    function automatic logic [23:0] pix_of(input int k);
        return {8'(3*k+3), 8'(3*k+2), 8'(3*k+1)};
    endfunction

    task automatic run_pkt(input int wc, input int depix, input int lead, input bit cmd,
                           input int hold, input bit gap, input bit busy, input string tag);
        int k = 0;
        int p = 0;
        int cyc = 0;
        bit ok;
        got_n = 0; done_seen = 0; last_tick = -1; done_tick = -1;
        @(negedge clk);
        pkt_start = 1'b1; pkt_wc = WC_W'(wc); cmd_mode = cmd; pix_pulse = 1'b0;
        @(negedge clk);
        pkt_start = 1'b0;
        while (!done_seen && cyc < 3000) begin
            byte_ready = (cyc < hold) ? 1'b0 : ((gap && (cyc % 3 == 0)) ? 1'b0 : 1'b1);
            pkt_start  = busy && (cyc == 5);
            if (busy && cyc == 5) pkt_wc = WC_W'(30);
            if (cmd) begin
                pix_pulse = 1'b1;
                pix_de    = 1'b0;      // R6: data-enable low throughout
                pix_data  = pix_of(k);
                if (hold > 0 && cyc == hold - 1) begin
                    check(pix_stall == 1'b1, "R7 stall on full buffer", int'(pix_stall), 1);
                    check(got_n == 0, "R7 no bytes while held", got_n, 0);
                end
                if (!pix_stall) k++;
            end else begin
                pix_pulse = (cyc % 4 == 0);
                if (pix_pulse) begin
                    pix_de   = (p >= lead) && (k < depix);
                    pix_data = pix_of(k);
                    if (pix_de) k++;
                    p++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        pix_pulse = 1'b0; pix_de = 1'b0; byte_ready = 1'b1; pkt_start = 1'b0;
        check(done_seen, {tag, " R10 done seen"}, int'(done_seen), 1);
        check(got_n == wc, {tag, " R1 byte count"}, got_n, wc);
        ok = 1;
        for (int i = 0; i < wc && i < 64 && i < got_n; i++) begin
            logic [7:0] exp;
            exp = (cmd || (i / 3) < depix) ? 8'(i + 1) : 8'h00;
            if (got_data[i] != exp) begin
                ok = 0;
                check(0, {tag, " R1 R3 R4 byte value"}, int'(got_data[i]), int'(exp));
            end
            if (got_last[i] != (i == wc - 1)) begin
                ok = 0;
                check(0, {tag, " R2 last flag"}, int'(got_last[i]), int'(i == wc - 1));
            end
        end
        check(ok, {tag, " R1 R2 payload content"}, int'(ok), 1);
        check(done_tick - last_tick == 1, {tag, " R10 done timing"}, done_tick - last_tick, 1);
        repeat (3) @(negedge clk);
    endtask

    // Vector fields: wc[31:16] depix[15:8] lead[7:4] gap[1] cmd[0]
    localparam logic [31:0] VEC [7] = '{
        {16'd9,  8'd3, 4'd0, 2'b0, 1'b0, 1'b0},  // exact fill
        {16'd9,  8'd1, 4'd2, 2'b0, 1'b0, 1'b0},  // R3 pad, R12 leading strobes
        {16'd7,  8'd5, 4'd0, 2'b0, 1'b0, 1'b0},  // R4 truncate inside pixel
        {16'd2,  8'd4, 4'd1, 2'b0, 1'b0, 1'b0},  // R4 count below one pixel
        {16'd10, 8'd0, 4'd0, 2'b0, 1'b0, 1'b1},  // R6 command mode
        {16'd11, 8'd2, 4'd0, 2'b0, 1'b0, 1'b0},  // R3 pad mid pixel
        {16'd13, 8'd0, 4'd0, 2'b0, 1'b1, 1'b1}   // R8 command with back-pressure
    };

    initial begin
        // watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(byte_valid == 1'b0, "R11 reset valid", int'(byte_valid), 0);
        check(pkt_done == 1'b0, "R11 reset done", int'(pkt_done), 0);
        check(pix_stall == 1'b1, "R11 reset stall", int'(pix_stall), 1);

        for (int v = 0; v < 7; v++) begin
            run_pkt(int'(VEC[v][31:16]), int'(VEC[v][15:8]), int'(VEC[v][7:4]),
                    VEC[v][0], 0, VEC[v][1], 1'b0, $sformatf("vec%0d", v));
        end

        // R5: zero word count
        @(negedge clk);
        pkt_start = 1'b1; pkt_wc = '0; cmd_mode = 1'b0;
        @(negedge clk);
        pkt_start = 1'b0;
        check(pkt_done == 1'b1, "R5 zero count done", int'(pkt_done), 1);
        check(byte_valid == 1'b0, "R5 zero count no byte", int'(byte_valid), 0);
        @(negedge clk);
        check(pkt_done == 1'b0, "R5 done single pulse", int'(pkt_done), 0);
        check(byte_valid == 1'b0, "R5 still no byte", int'(byte_valid), 0);

        // R7: command mode with sink held off
        run_pkt(30, 0, 0, 1'b1, 10, 1'b0, 1'b0, "hold");

        // R9: second start while busy is ignored
        run_pkt(6, 4, 0, 1'b0, 0, 1'b0, 1'b1, "busy R9");
        check(pix_stall == 1'b1 && byte_valid == 1'b0, "R9 idle after packet",
              int'(byte_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule